// File: doc/BRIEF.md
# Programmable Threshold Offset Store

This block keeps the two threshold offsets that a queue's almost-empty and almost-full flag comparators measure against: one counted from the empty boundary and one from the full boundary. Each offset is twice the data-bus width, 18 bits by default. A master reset preloads both offsets with one of two default values. The level of the load-select input during that reset picks the default. The same level also fixes how software may reprogram the offsets until the next master reset. With load-select low, the defaults are 127 and reprogramming uses parallel bus words. With load-select high, the defaults are 1,023 and reprogramming uses a serial bit stream.

Writes happen on the write clock. In parallel mode, each strobe stores one bus word into the next of four slots in a fixed rotation. In serial mode, each strobe shifts one bit into a 36-bit chain. On the read clock, a readback strobe presents the next slot on the readback bus in the same rotation as parallel loading. Readback works in either mode. A partial reset returns both slot counters to the first slot and keeps the stored offsets and the mode. The flag comparators themselves are outside this block.

Top module: `ofs_prog_regs`

## Requirements
- R1: A write-clock edge with mst_rst_n low and ld_sel low sets both offsets to 127 and selects parallel mode.
- R2: A write-clock edge with mst_rst_n low and ld_sel high sets both offsets to 1,023 and selects serial mode.
- R3: In parallel mode, a write-clock edge with wen and ld_sel high stores d into the current slot and then advances the slot. The slots rotate in the order 0, 1, 2, 3 and then wrap to 0. Slot 0 is empty_ofs[8:0], slot 1 is empty_ofs[17:9], slot 2 is full_ofs[8:0] and slot 3 is full_ofs[17:9].
- R4: In serial mode, a write-clock edge with sen and ld_sel high shifts si into a 36-bit chain. After 36 such edges, the first bit shifted in sits at empty_ofs[0], bit 17 sits at empty_ofs[17], and bits 18 to 35 form full_ofs from its LSB upward.
- R5: The mode latched at master reset locks the programming method. Serial strobes change nothing in parallel mode, and parallel strobes change nothing in serial mode.
- R6: A read-clock edge with ren and ld_sel high loads rd_q with the current readback slot and then advances that slot. Readback uses the slot map and wrap order of R3. At all other read-clock edges outside reset, rd_q holds its value.
- R7: While prt_rst_n is low, the offsets and the mode do not change and load strobes are ignored. The write slot and the readback slot both return to slot 0, and rd_q clears to 0.
- R8: A master reset returns the write slot and the readback slot to slot 0 and clears rd_q.
- R9: Readback returns the stored offsets in serial mode as well as in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; loads and master-reset defaults take effect on its rising edge |
| rd_clk | input | 1 | Read-side clock for readback |
| mst_rst_n | input | 1 | Synchronous active-low master reset, sampled by both clocks |
| prt_rst_n | input | 1 | Synchronous active-low partial reset; returns the slot counters to slot 0 only |
| ld_sel | input | 1 | Selects defaults and mode during master reset; qualifies every load and readback strobe |
| wen | input | 1 | Parallel load strobe |
| sen | input | 1 | Serial load strobe |
| si | input | 1 | Serial data bit |
| d | input | 9 | Parallel load word |
| ren | input | 1 | Readback strobe |
| empty_ofs | output | 18 | Threshold offset from the empty boundary |
| full_ofs | output | 18 | Threshold offset from the full boundary |
| rd_q | output | 9 | Readback word |

## Verification
The bench uses the default build: a 9-bit bus, 18-bit offsets and four slots. A four-slot rotation and a 36-bit serial chain are short enough to drive through completely for every pattern in a sweep. The bench computes each offset pair arithmetically from the sweep index. After every full parallel load or serial shift, it reads back all four slots. It also checks readback past the wrap point, cross-mode strobes, partial resets that land in the middle of a word sequence, and master resets with either level of ld_sel.

// File: rtl/ofs_pkg.sv
// Shared types for the programmable threshold offset store.
package ofs_pkg;
    // Programming method, fixed by ld_sel at master reset.
    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_mode_e;
endpackage

// File: rtl/ofs_slot_ctr.sv
// Slot counter: steps through WORDS slots and wraps back to slot 0.
// Assumes: clr_n is a synchronous active-low clear that takes priority over step.
module ofs_slot_ctr #(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    // Purpose: clear to slot 0, or advance one slot with wrap.
    always_ff @(posedge clk) begin
        if (!clr_n)
            idx <= '0;
        else if (step)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/ofs_wr_store.sv
// Write-side offset storage. Holds {full, empty} as one chain, latches the
// programming mode and preloads the defaults at master reset, and applies
// parallel or serial loads.
// Assumes: all inputs are synchronous to clk; resets are synchronous active-low.
module ofs_wr_store
    import ofs_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023,
    localparam int OFS_W  = 2 * DATA_W,
    localparam int CAT_W  = 2 * OFS_W,
    localparam int WORDS  = CAT_W / DATA_W
) (
    input  logic              clk,
    input  logic              mst_rst_n,
    input  logic              prt_rst_n,
    input  logic              ld_sel,
    input  logic              wen,
    input  logic              sen,
    input  logic              si,
    input  logic [DATA_W-1:0] d,
    output logic [CAT_W-1:0]  cat_q
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [OFS_W-1:0] DP = OFS_W'(DEF_PAR);
    localparam logic [OFS_W-1:0] DS = OFS_W'(DEF_SER);

    prog_mode_e       mode_q;
    logic             par_hit;
    logic             ser_hit;
    logic [IDX_W-1:0] widx;

    // Purpose: decode the load strobes allowed by the latched mode.
    always_comb begin
        par_hit = (mode_q == PROG_PAR) && ld_sel && wen && prt_rst_n;
        ser_hit = (mode_q == PROG_SER) && ld_sel && sen && prt_rst_n;
    end

    ofs_slot_ctr #(.WORDS(WORDS)) u_wslot (
        .clk   (clk),
        .clr_n (mst_rst_n && prt_rst_n),
        .step  (par_hit),
        .idx   (widx)
    );

    // Purpose: reset defaults and mode, serial shift, or parallel slot write.
    always_ff @(posedge clk) begin
        if (!mst_rst_n) begin
            mode_q <= ld_sel ? PROG_SER : PROG_PAR;
            cat_q  <= ld_sel ? {DS, DS} : {DP, DP};
        end else if (ser_hit) begin
            cat_q <= {si, cat_q[CAT_W-1:1]};
        end else if (par_hit) begin
            for (int k = 0; k < WORDS; k++) begin
                if (widx == IDX_W'(k))
                    cat_q[k*DATA_W +: DATA_W] <= d;
            end
        end
    end

    // R1 R2
    default_load_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        $rose(mst_rst_n) |-> (cat_q == ((mode_q == PROG_SER) ? {DS, DS} : {DP, DP}))
                             && ((mode_q == PROG_SER) == $past(ld_sel)));

    // R7
    prs_keep_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        !prt_rst_n |=> $stable(cat_q) && $stable(mode_q));

    // R5
    mode_lock_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (mode_q == PROG_SER && !sen) || (mode_q == PROG_PAR && !wen) |=> $stable(cat_q));

    // R3
    par_step_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        par_hit && prt_rst_n |=> (widx != $past(widx)));
endmodule

// File: rtl/ofs_rd_port.sv
// Read-side readback port. Presents one slot of the offset chain per strobe
// and holds the word between strobes.
// Assumes: cat stays stable while readback strobes are issued, so it may be
// sampled on rd_clk without synchronisers. Resets are synchronous active-low.
module ofs_rd_port #(
    parameter int DATA_W = 9,
    localparam int CAT_W = 4 * DATA_W,
    localparam int WORDS = 4
) (
    input  logic              clk,
    input  logic              mst_rst_n,
    input  logic              prt_rst_n,
    input  logic              ld_sel,
    input  logic              ren,
    input  logic [CAT_W-1:0]  cat,
    output logic [DATA_W-1:0] rd_q
);
    localparam int IDX_W = $clog2(WORDS);

    logic              rd_hit;
    logic [IDX_W-1:0]  ridx;
    logic [DATA_W-1:0] sel_word;

    assign rd_hit = ld_sel && ren && prt_rst_n;

    ofs_slot_ctr #(.WORDS(WORDS)) u_rslot (
        .clk   (clk),
        .clr_n (mst_rst_n && prt_rst_n),
        .step  (rd_hit),
        .idx   (ridx)
    );

    // Purpose: select the word of the current readback slot.
    always_comb begin
        sel_word = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (ridx == IDX_W'(k))
                sel_word = cat[k*DATA_W +: DATA_W];
        end
    end

    // Purpose: register the readback word on each strobe.
    always_ff @(posedge clk) begin
        if (!(mst_rst_n && prt_rst_n))
            rd_q <= '0;
        else if (rd_hit)
            rd_q <= sel_word;
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        (prt_rst_n && !(ren && ld_sel)) |=> $stable(rd_q));

    // R7
    rd_prs_clr_chk: assert property (@(posedge clk) disable iff (!mst_rst_n)
        !prt_rst_n |=> (rd_q == '0));
endmodule

// File: rtl/ofs_prog_regs.sv
// Top of the programmable threshold offset store: the write-side storage and
// the read-side readback port, joined by the offset chain.
// Assumes: readback happens only while no load is in progress.
module ofs_prog_regs #(
    parameter int DATA_W  = 9,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023,
    localparam int OFS_W  = 2 * DATA_W,
    localparam int CAT_W  = 2 * OFS_W
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mst_rst_n,
    input  logic              prt_rst_n,
    input  logic              ld_sel,
    input  logic              wen,
    input  logic              sen,
    input  logic              si,
    input  logic [DATA_W-1:0] d,
    input  logic              ren,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rd_q
);
    logic [CAT_W-1:0] cat;

    ofs_wr_store #(
        .DATA_W  (DATA_W),
        .DEF_PAR (DEF_PAR),
        .DEF_SER (DEF_SER)
    ) u_store (
        .clk       (wr_clk),
        .mst_rst_n (mst_rst_n),
        .prt_rst_n (prt_rst_n),
        .ld_sel    (ld_sel),
        .wen       (wen),
        .sen       (sen),
        .si        (si),
        .d         (d),
        .cat_q     (cat)
    );

    ofs_rd_port #(.DATA_W(DATA_W)) u_rport (
        .clk       (rd_clk),
        .mst_rst_n (mst_rst_n),
        .prt_rst_n (prt_rst_n),
        .ld_sel    (ld_sel),
        .ren       (ren),
        .cat       (cat),
        .rd_q      (rd_q)
    );

    assign empty_ofs = cat[OFS_W-1:0];
    assign full_ofs  = cat[CAT_W-1:OFS_W];
endmodule

// File: tb/ofs_prog_regs_bench.sv
module ofs_prog_regs_bench;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       mst_rst_n = 1'b0;
    logic       prt_rst_n = 1'b1;
    logic       ld_sel = 1'b0;
    logic       wen = 1'b0;
    logic       sen = 1'b0;
    logic       si = 1'b0;
    logic [8:0] d = '0;
    logic       ren = 1'b0;
    logic [17:0] empty_ofs, full_ofs;
    logic [8:0]  rd_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 wr_clk = ~wr_clk;
    initial begin
        #7;
        forever #10 rd_clk = ~rd_clk;
    end

    ofs_prog_regs u_ofs_prog_regs (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst_n(mst_rst_n),
        .prt_rst_n(prt_rst_n), .ld_sel(ld_sel), .wen(wen), .sen(sen),
        .si(si), .d(d), .ren(ren), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .rd_q(rd_q)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic master_reset(input logic sel);
        @(negedge wr_clk);
        mst_rst_n = 1'b0; ld_sel = sel;
        #60;
        @(negedge wr_clk);
        mst_rst_n = 1'b1; ld_sel = 1'b0;
        #40;
    endtask

    task automatic partial_reset(input logic strobe);
        @(negedge wr_clk);
        prt_rst_n = 1'b0; ld_sel = strobe; wen = strobe; sen = strobe; ren = strobe; d = 9'h1AB; si = 1'b1;
        #60;
        @(negedge wr_clk);
        prt_rst_n = 1'b1; ld_sel = 1'b0; wen = 1'b0; sen = 1'b0; ren = 1'b0;
        #40;
    endtask

    task automatic par_word(input logic [8:0] w);
        @(negedge wr_clk);
        ld_sel = 1'b1; wen = 1'b1; d = w;
        @(negedge wr_clk);
        ld_sel = 1'b0; wen = 1'b0;
    endtask

    task automatic ser_bit(input logic b);
        @(negedge wr_clk);
        ld_sel = 1'b1; sen = 1'b1; si = b;
        @(negedge wr_clk);
        ld_sel = 1'b0; sen = 1'b0;
    endtask

    task automatic par_load(input logic [17:0] e, input logic [17:0] f);
        logic [35:0] c;
        c = {f, e};
        for (int k = 0; k < 4; k++) par_word(c[k*9 +: 9]);
    endtask

    task automatic ser_load(input logic [17:0] e, input logic [17:0] f);
        logic [35:0] c;
        c = {f, e};
        for (int i = 0; i < 36; i++) ser_bit(c[i]);
    endtask

    task automatic read_word(input string req, input logic [8:0] exp);
        @(negedge rd_clk);
        ld_sel = 1'b1; ren = 1'b1;
        @(negedge rd_clk);
        ld_sel = 1'b0; ren = 1'b0;
        #3;
        chk(req, 36'(rd_q), 36'(exp));
    endtask

    task automatic read_all(input string req, input logic [17:0] e, input logic [17:0] f);
        logic [35:0] c;
        c = {f, e};
        for (int k = 0; k < 4; k++) read_word(req, c[k*9 +: 9]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [17:0] e, f;
        // R1 parallel defaults
        master_reset(1'b0);
        chk("R1 empty", 36'(empty_ofs), 36'd127);
        chk("R1 full", 36'(full_ofs), 36'd127);
        chk("R8 rd_q cleared", 36'(rd_q), 36'd0);
        // R6 readback of defaults and wrap
        read_all("R6 default readback", 18'd127, 18'd127);
        read_word("R6 wrap", 9'd127);
        // R7 partial reset with strobes active: offsets kept, slot back to 0
        partial_reset(1'b1);
        chk("R7 empty kept", 36'(empty_ofs), 36'd127);
        chk("R7 full kept", 36'(full_ofs), 36'd127);
        chk("R7 rd_q cleared", 36'(rd_q), 36'd0);
        read_word("R7 read slot 0", 9'd127);
        partial_reset(1'b0);
        // R3 parallel sweep
        for (int p = 0; p < 16; p++) begin
            e = 18'(p * 9973 + 11);
            f = 18'(~(p * 5521 + 3));
            par_load(e, f);
            chk("R3 empty", 36'(empty_ofs), 36'(e));
            chk("R3 full", 36'(full_ofs), 36'(f));
            read_all("R6 parallel readback", e, f);
        end
        // R5 serial strobes ignored in parallel mode
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        chk("R5 par mode empty", 36'(empty_ofs), 36'(e));
        chk("R5 par mode full", 36'(full_ofs), 36'(f));
        // R7 partial reset mid-sequence realigns write slot
        par_word(9'h055);
        par_word(9'h0AA);
        partial_reset(1'b0);
        par_load(18'h2A5A5, 18'h15A5A);
        chk("R7 realigned empty", 36'(empty_ofs), 36'h2A5A5);
        chk("R7 realigned full", 36'(full_ofs), 36'h15A5A);
        // R8 master reset mid-sequence realigns write slot
        par_word(9'h1FF);
        master_reset(1'b0);
        par_load(18'h00123, 18'h3FEDC);
        chk("R8 realigned empty", 36'(empty_ofs), 36'h00123);
        chk("R8 realigned full", 36'(full_ofs), 36'h3FEDC);
        read_word("R6 read slot 0", 9'h123);
        // R2 serial defaults, readback restarts at slot 0
        master_reset(1'b1);
        chk("R2 empty", 36'(empty_ofs), 36'd1023);
        chk("R2 full", 36'(full_ofs), 36'd1023);
        read_all("R8 R9 default readback", 18'd1023, 18'd1023);
        // R4 serial sweep
        for (int p = 0; p < 8; p++) begin
            e = 18'(p * 31337 + 7);
            f = 18'(p * 12011 + 200000);
            ser_load(e, f);
            chk("R4 empty", 36'(empty_ofs), 36'(e));
            chk("R4 full", 36'(full_ofs), 36'(f));
            read_all("R9 serial readback", e, f);
        end
        // R5 parallel strobes ignored in serial mode
        par_load(18'h3FFFF, 18'h00000);
        chk("R5 ser mode empty", 36'(empty_ofs), 36'(e));
        chk("R5 ser mode full", 36'(full_ofs), 36'(f));
        // R7 partial reset keeps serial mode and offsets
        partial_reset(1'b1);
        chk("R7 ser kept empty", 36'(empty_ofs), 36'(e));
        ser_load(18'h0F0F0, 18'h30303);
        chk("R7 ser mode kept", 36'(full_ofs), 36'h30303);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule